// File: doc/BRIEF.md
# Packed Byte Shuffle Unit

The unit rearranges the bytes of a table operand under the control of an index operand. Each result byte looks up one byte of the table, chosen by the low bits of the index byte in the same position, unless the top bit of that index byte is set, in which case the result byte is forced to zero. The unit has two operand spans. In the wide span the full 16-byte table is reachable from every lane. In the narrow span only the low 8 bytes of the table and the low 8 lanes take part.

The result is captured in an output register and offered with a valid/ready handshake. A new operand pair is accepted whenever the output register is empty or is being drained in the same cycle. The unit therefore sustains one operation per cycle with one cycle of latency. Instruction decode and operand fetch are handled upstream.

Top module: `byte_shuffle_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and out_data is all zeros.
- R2: In either span, a result byte whose index byte has bit 7 set is 0x00, including for index values 0x80 and 0xFF.
- R3: In the wide span (in_wide = 1), result byte i equals table byte k, where k = index byte i bits 3:0. Bit 3 set selects a byte from the upper half of the table (bytes 8 to 15), whichever half lane i lies in.
- R4: In the wide span, index bits 6:4 do not change the selected byte.
- R5: In the narrow span (in_wide = 0), result byte i for i < 8 equals table byte k, where k = index byte i bits 2:0. Index bits 6:3 and table bytes 8 to 15 do not affect the result.
- R6: In the narrow span, result bytes 8 to 15 are 0x00, whatever the upper index bytes hold.
- R7: An operand pair accepted on a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high right after that edge. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R8: in_ready is high exactly when out_valid is low or out_ready is high. A result consumed while no new operand is accepted leaves out_valid low after the edge.
- R9: Byte 0 of every operand and of the result occupies bits 7:0, and byte k occupies bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair this cycle |
| in_wide | input | 1 | 1 = 16-byte span, 0 = 8-byte span |
| in_table | input | 128 | Table operand, byte 0 in bits 7:0 |
| in_index | input | 128 | Index operand, one control byte per lane |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Shuffled result, byte 0 in bits 7:0 |

## Verification
The only state in the unit is the result register and its valid flag. A wrong lane selection, an ignored zeroing bit or a wrong span decode therefore shows up on out_data in the first cycle after the operand pair is accepted, and comparing against a lookup model isolates the failing lane. A wrong valid flag shows up at once on in_ready, or as a lost or repeated result across a stall. The bench makes stalls of several cycles and drains with no new input, so both kinds of error appear within a few cycles.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   localparam int unsigned BSU_DEF_NBYTES = 16;
   localparam int unsigned BSU_DEF_BW     = 8;

   // Operand span: narrow uses half the table and half the lanes.
   typedef enum logic {
      SPAN_HALF = 1'b0,
      SPAN_FULL = 1'b1
   } bsu_span_e;

endpackage

// File: rtl/bsu_lane.sv
module bsu_lane
   import bsu_pkg::*;
#(
   parameter int unsigned NBYTES = BSU_DEF_NBYTES,
   parameter int unsigned BW     = BSU_DEF_BW,
   parameter bit          UPPER  = 1'b0
) (
   input  logic [NBYTES*BW-1:0] tbl_i,
   input  logic [BW-1:0]        idx_i,
   input  bsu_span_e            span_i,
   output logic [BW-1:0]        byte_o
);

   localparam int unsigned IDXW  = $clog2(NBYTES);
   localparam int unsigned HALF  = NBYTES / 2;
   localparam int unsigned HIDXW = $clog2(HALF);

   logic [BW-1:0]   tbl_b [NBYTES];
   logic [IDXW-1:0] sel;
   logic            kill;
   logic            unused_idx_bits;

   for (genvar k = 0; k < NBYTES; k++) begin : g_view
      assign tbl_b[k] = tbl_i[k*BW +: BW];
   end

   assign unused_idx_bits = ^idx_i[BW-2:IDXW];

   always_comb begin
      if (span_i == SPAN_FULL) begin
         sel = idx_i[IDXW-1:0];
      end else begin
         sel = {1'b0, idx_i[HIDXW-1:0]};
      end
   end

   if (UPPER) begin : g_upper
      // Lanes in the upper half are silent in the narrow span.
      assign kill = idx_i[BW-1] | (span_i == SPAN_HALF);
   end else begin : g_lower
      assign kill = idx_i[BW-1];
   end

   assign byte_o = kill ? '0 : tbl_b[sel];

endmodule

// File: rtl/bsu_ostage.sv
module bsu_ostage #(
   parameter int unsigned W = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] d_i,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] q_o
);

   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         q_o       <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         q_o       <= d_i;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(q_o));

   // R7
   accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R8
   drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
   import bsu_pkg::*;
#(
   parameter int unsigned NBYTES = BSU_DEF_NBYTES,
   parameter int unsigned BW     = BSU_DEF_BW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_wide,
   input  logic [NBYTES*BW-1:0] in_table,
   input  logic [NBYTES*BW-1:0] in_index,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [NBYTES*BW-1:0] out_data
);

   localparam int unsigned W    = NBYTES * BW;
   localparam int unsigned HALF = NBYTES / 2;
   localparam int unsigned IDXW = $clog2(NBYTES);

   if (NBYTES < 4 || (NBYTES & (NBYTES - 1)) != 0) begin : g_bad_nbytes
      $error("byte_shuffle_unit: NBYTES must be a power of two of at least 4");
   end
   if (BW < IDXW + 2) begin : g_bad_bw
      $error("byte_shuffle_unit: BW too narrow for index and zero bit");
   end

   bsu_span_e     span;
   logic [W-1:0]  shuf;

   assign span = in_wide ? SPAN_FULL : SPAN_HALF;

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      bsu_lane #(
         .NBYTES (NBYTES),
         .BW     (BW),
         .UPPER  (i >= HALF)
      ) u_lane (
         .tbl_i  (in_table),
         .idx_i  (in_index[i*BW +: BW]),
         .span_i (span),
         .byte_o (shuf[i*BW +: BW])
      );

      // R2
      lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && in_ready && in_index[i*BW + BW - 1]
         |=> out_data[i*BW +: BW] == '0);
   end

   bsu_ostage #(
      .W (W)
   ) u_ostage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .d_i       (shuf),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .q_o       (out_data)
   );

   // R6
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_wide |=> out_data[W-1:HALF*BW] == '0);

endmodule

// File: tb/byte_shuffle_unit_bench.sv
`timescale 1ns/1ps
module byte_shuffle_unit_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic         in_wide = 1'b1;
   logic [127:0] in_table = '0;
   logic [127:0] in_index = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   byte_shuffle_unit u_byte_shuffle_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_wide   (in_wide),
      .in_table  (in_table),
      .in_index  (in_index),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   // {wide, table, index, expected}
   localparam logic [384:0] VEC [6] = '{
      {1'b1, 128'h0F0E0D0C0B0A09080706050403020100,
             128'h0F0E0D0C0B0A09080706050403020100,
             128'h0F0E0D0C0B0A09080706050403020100},
      {1'b1, 128'h0F0E0D0C0B0A09080706050403020100,
             128'h000102030405060708090A0B0C0D0E0F,
             128'h000102030405060708090A0B0C0D0E0F},
      {1'b1, 128'h0F0E0D0C0B0A09080706050403020100,
             128'h80FF7F703F1F2F4F8A0B0C0DF0E01122,
             128'h00000F000F0F0F0F000B0C0D00000102},
      {1'b0, 128'hFFEEDDCCBBAA99887766554433221100,
             128'h01020304050607080F1E2D3C4B5A8769,
             128'h00000000000000007766554433220011},
      {1'b1, 128'hFFEEDDCCBBAA99887766554433221100,
             {16{8'h08}},
             {16{8'h88}}},
      {1'b1, 128'hFFEEDDCCBBAA99887766554433221100,
             {16{8'h80}},
             128'h0}
   };

   function automatic logic [127:0] model(input bit wide, input logic [127:0] t,
                                          input logic [127:0] x);
      logic [127:0] r;
      r = '0;
      for (int i = 0; i < 16; i++) begin
         logic [7:0] b;
         int k;
         b = x[i*8 +: 8];
         k = wide ? int'(b[3:0]) : int'(b[2:0]);
         if ((!wide && i >= 8) || b[7]) r[i*8 +: 8] = 8'h00;
         else                           r[i*8 +: 8] = t[k*8 +: 8];
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one operand pair with out_ready high, check the result after the edge.
   task automatic run_one(input string req, input bit wide, input logic [127:0] t,
                          input logic [127:0] x, input logic [127:0] exp);
      @(negedge clk);
      in_valid  = 1'b1;
      in_wide   = wide;
      in_table  = t;
      in_index  = x;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
      chk(req, out_data, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
      chk("R1 in_ready",  {127'd0, in_ready},  128'd1);
      chk("R1 out_data",  out_data, 128'd0);

      // Vector table: R2 R3 R4 R5 R6 R9
      for (int v = 0; v < 6; v++) begin
         run_one($sformatf("R3/R5 vector %0d", v), VEC[v][384], VEC[v][383:256],
                 VEC[v][255:128], VEC[v][127:0]);
      end

      // R9: single byte at position 5 moved to lane 0
      run_one("R9 byte order", 1'b1, 128'h0000_0000_0000_0000_0000_AB00_0000_0000,
              {{15{8'h80}}, 8'h05}, 128'h0000_0000_0000_0000_0000_0000_0000_00AB);

      // R4: same low bits, different bits 6:4 give the same result
      run_one("R4 upper bits", 1'b1, 128'hFFEEDDCCBBAA99887766554433221100,
              {16{8'h7A}}, {16{8'hAA}});

      // R5: narrow span ignores table bytes 8..15 and index bit 3
      run_one("R5 ignore bit3", 1'b0, 128'h123456789ABCDEF0_7766554433221100,
              {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
               8'h0F, 8'h0E, 8'h0D, 8'h0C, 8'h0B, 8'h0A, 8'h09, 8'h08},
              128'h0000000000000000_7766554433221100);

      // Randomized lanes against the lookup model, with 0x80 and 0xFF injected (R2 R3 R5 R6)
      for (int n = 0; n < 300; n++) begin
         logic [127:0] t, x;
         bit w;
         t = {$urandom, $urandom, $urandom, $urandom};
         x = {$urandom, $urandom, $urandom, $urandom};
         w = $urandom_range(0, 1);
         if (n % 5 == 0) x[8*(n%16) +: 8] = 8'h80;
         if (n % 7 == 0) x[8*((n+3)%16) +: 8] = 8'hFF;
         run_one(w ? "R3 random" : "R5/R6 random", w, t, x, model(w, t, x));
      end

      // R7 R8 stall and drain
      @(negedge clk);
      in_valid  = 1'b1;
      in_wide   = 1'b1;
      in_table  = 128'h0F0E0D0C0B0A09080706050403020100;
      in_index  = {16{8'h03}};
      out_ready = 1'b0;
      @(negedge clk);
      in_index = {16{8'h0C}};
      for (int s = 0; s < 3; s++) begin
         chk("R7 stall valid", {127'd0, out_valid}, 128'd1);
         chk("R7 stall hold",  out_data, {16{8'h03}});
         chk("R8 stall ready", {127'd0, in_ready}, 128'd0);
         @(negedge clk);
      end
      out_ready = 1'b1;
      #1;
      chk("R8 ready on drain", {127'd0, in_ready}, 128'd1);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7 next result", out_data, {16{8'h0C}});
      chk("R7 next valid",  {127'd0, out_valid}, 128'd1);
      @(negedge clk);
      chk("R8 drained", {127'd0, out_valid}, 128'd0);

      // R1 reset in mid-stream
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 re-reset valid", {127'd0, out_valid}, 128'd0);
      chk("R1 re-reset data",  out_data, 128'd0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule